// File: doc/BRIEF.md
# CAN bit timing synchronizer

This block recovers the bit timing of a CAN node from the received bus line. A prescaler turns the system clock into a time-quantum enable. On each quantum a counter steps through the positions of one bit, from 0 up to the configured number of quanta minus one. Falling bus edges, which go from recessive (1) to dominant (0), pull this counter back into line with the transmitters on the bus. An edge that the frame logic marks as a start of frame realigns the counter at once. Any other edge moves the counter by no more than the jump-width setting.

Once per bit the block samples the line at the configured sampling position. It returns that level together with a one-cycle strobe, and that strobe is the timing reference for the frame logic. A second strobe marks each bit boundary. The frame logic may hand over the next transmit bit at any time. The block buffers that bit and drives it onto the transmit output only at the next boundary.

Top module: `can_bit_sync`

## Requirements
- R1: `tq_en` is high for exactly one clock in every `cfg_div`+1 clocks. All counter movement and all strobes happen only on those quanta, so with `cfg_nq`=8 and `cfg_div`=3 two boundary strobes are 32 clocks apart.
- R2: When no edge is seen, the quantum counter runs 0..`cfg_nq`-1. A boundary strobe marks every quantum 0, so boundary strobes are `cfg_nq` quanta apart. The sample strobe appears exactly `cfg_sp` quanta after each boundary strobe and at no other quantum of that bit. Both strobes are low in reset.
- R3: Take a falling edge that is first seen on a quantum while `hsync_ok` is 1. That quantum becomes quantum 1 of a new bit, at any phase, and the boundary strobe fires on it.
- R4: Let p be the position the counter would have reached on the edge quantum. If 1 <= p < `cfg_sp`, the edge is late with error e = p-1. The counter becomes p - min(e, `cfg_sjw`), so the next boundary comes `cfg_nq` - that value quanta later.
- R5: If p >= `cfg_sp`, or if p = 0, the edge is early with magnitude `cfg_nq`+1-p (1 when p = 0). If the magnitude is at most `cfg_sjw`, the counter is loaded with 1 and the boundary strobe fires on that quantum. Otherwise the counter becomes p+`cfg_sjw`. A value equal to `cfg_nq` wraps to 0 and fires the boundary strobe.
- R6: A rising bus edge, from dominant to recessive, never moves the bit timing.
- R7: After any synchronization, further falling edges are ignored. This lasts until a recessive level is sampled at a sampling position.
- R8: No falling edge causes a synchronization while `tx_out` drives dominant (0).
- R9: A pulse on `tx_req` stores `tx_bit`. `tx_out` changes only on boundary quanta. At the next boundary it takes the stored bit, and at a boundary with nothing stored it returns to recessive (1). `tx_out` is 1 in reset.
- R10: `smp_bit` is the level of `rx_in` on the quantum that the sample strobe reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Clocks per quantum minus one |
| cfg_nq | input | QW | Quanta per bit (8..25) |
| cfg_sp | input | QW | Sampling position in quanta (2..cfg_nq-1) |
| cfg_sjw | input | JW | Jump width in quanta (1..4) |
| rx_in | input | 1 | Received bus level, 1 recessive |
| hsync_ok | input | 1 | Frame logic allows hard synchronization |
| tx_req | input | 1 | Store tx_bit for the next boundary |
| tx_bit | input | 1 | Bit to transmit |
| tq_en | output | 1 | Time-quantum enable |
| smp_stb | output | 1 | One-cycle sample strobe, once per bit |
| smp_bit | output | 1 | Sampled bus level |
| bnd_stb | output | 1 | One-cycle bit-boundary strobe |
| tx_out | output | 1 | Transmit level to the transceiver |

## Verification
The bench keeps the default widths and the direct receive path. It sets the prescaler to one clock per quantum, so every clock is a quantum and each counter position is an exact clock offset from a boundary strobe. It sweeps every quanta-per-bit value from 8 to 25 at the extreme sampling positions. It then places a one-quantum dominant pulse at each position of a bit, for six bit shapes and all four jump widths, and with hard synchronization enabled. This reaches every late, early, wrapping and capped case, and the bench computes the expected boundary spacing arithmetically. A separate run with four clocks per quantum covers the prescaler.

// File: rtl/can_bs_pkg.sv
package can_bs_pkg;
   typedef enum logic [1:0] {
      SY_NONE  = 2'd0,
      SY_HARD  = 2'd1,
      SY_LATE  = 2'd2,
      SY_EARLY = 2'd3
   } sync_kind_e;
endpackage

// File: rtl/bs_quantum_gen.sv
module bs_quantum_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             q_en
);
   logic [DIV_W-1:0] cnt_q;

   assign q_en = (cnt_q >= div);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (q_en) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/bs_phase_ctrl.sv
module bs_phase_ctrl
   import can_bs_pkg::*;
#(
   parameter int QW = 5,
   parameter int JW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          q_en,
   input  logic          rx_s,
   input  logic          hsync_ok,
   input  logic          tx_dom,
   input  logic [QW-1:0] cfg_nq,
   input  logic [QW-1:0] cfg_sp,
   input  logic [JW-1:0] cfg_sjw,
   output logic          smp_stb,
   output logic          smp_bit,
   output logic          bnd_stb,
   output logic          bnd_evt,
   output logic          sync_hit,
   output logic [QW-1:0] cnt_o
);
   localparam int QW1 = QW + 1;

   logic [QW-1:0]  cnt_q;
   logic           prev_q, inh_q;
   logic [QW1-1:0] nq_w, sp_w, sjw_w, nc_w, e_w, mag_w, adv_w, cut_w, nxt_w;
   logic           bnd_now, at_sp;
   sync_kind_e     kind;

   always_comb begin
      nq_w  = {1'b0, cfg_nq};
      sp_w  = {1'b0, cfg_sp};
      sjw_w = QW1'(cfg_sjw);
      nc_w  = ({1'b0, cnt_q} == nq_w - QW1'(1)) ? '0 : {1'b0, cnt_q} + QW1'(1);
      e_w   = nc_w - QW1'(1);
      mag_w = (nc_w == '0) ? QW1'(1) : nq_w + QW1'(1) - nc_w;
      adv_w = nc_w + sjw_w;
      cut_w = (e_w < sjw_w) ? e_w : sjw_w;
      at_sp = (nc_w == sp_w);
      sync_hit = q_en & prev_q & ~rx_s & ~inh_q & ~tx_dom;
      kind    = SY_NONE;
      nxt_w   = nc_w;
      bnd_now = (nc_w == '0);
      if (sync_hit) begin
         if (hsync_ok) begin
            kind = SY_HARD;  nxt_w = QW1'(1); bnd_now = 1'b1;
         end else if (nc_w != '0 && nc_w < sp_w) begin
            kind = SY_LATE;  nxt_w = nc_w - cut_w; bnd_now = 1'b0;
         end else begin
            kind = SY_EARLY;
            if (mag_w <= sjw_w) begin
               nxt_w = QW1'(1); bnd_now = 1'b1;
            end else if (adv_w == nq_w) begin
               nxt_w = '0; bnd_now = 1'b1;
            end else begin
               nxt_w = adv_w; bnd_now = 1'b0;
            end
         end
      end
   end

   assign bnd_evt = q_en & bnd_now;
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         prev_q  <= 1'b1;
         inh_q   <= 1'b0;
         smp_stb <= 1'b0;
         smp_bit <= 1'b1;
         bnd_stb <= 1'b0;
      end else if (q_en) begin
         cnt_q   <= nxt_w[QW-1:0];
         prev_q  <= rx_s;
         smp_stb <= at_sp;
         bnd_stb <= bnd_now;
         if (at_sp) smp_bit <= rx_s;
         if (kind != SY_NONE)  inh_q <= 1'b1;
         else if (at_sp && rx_s) inh_q <= 1'b0;
      end else begin
         smp_stb <= 1'b0;
         bnd_stb <= 1'b0;
      end
   end
endmodule

// File: rtl/bs_tx_hold.sv
module bs_tx_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_req,
   input  logic tx_bit,
   input  logic bnd_evt,
   output logic tx_out
);
   logic pend_q, buf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_out <= 1'b1;
         pend_q <= 1'b0;
         buf_q  <= 1'b1;
      end else begin
         if (bnd_evt) tx_out <= pend_q ? buf_q : 1'b1;
         if (tx_req) begin
            pend_q <= 1'b1;
            buf_q  <= tx_bit;
         end else if (bnd_evt) begin
            pend_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/can_bit_sync.sv
module can_bit_sync #(
   parameter int DIV_W          = 8,
   parameter int QW             = 5,
   parameter int JW             = 3,
   parameter int RX_SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [QW-1:0]    cfg_nq,
   input  logic [QW-1:0]    cfg_sp,
   input  logic [JW-1:0]    cfg_sjw,
   input  logic             rx_in,
   input  logic             hsync_ok,
   input  logic             tx_req,
   input  logic             tx_bit,
   output logic             tq_en,
   output logic             smp_stb,
   output logic             smp_bit,
   output logic             bnd_stb,
   output logic             tx_out
);
   generate
      if (QW < 5) begin : g_bad_qw
         $error("QW must hold 25 quanta");
      end
      if (JW < 3 || JW > QW) begin : g_bad_jw
         $error("JW must hold a jump width of 4 and not exceed QW");
      end
      if (DIV_W < 1 || RX_SYNC_STAGES < 0) begin : g_bad_misc
         $error("illegal prescaler width or synchronizer depth");
      end
   endgenerate

   logic          rx_s, bnd_evt, sync_hit;
   logic [QW-1:0] q_cnt;

   generate
      if (RX_SYNC_STAGES == 0) begin : g_rx_direct
         assign rx_s = rx_in;
      end else begin : g_rx_sync
         logic [RX_SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= RX_SYNC_STAGES'({sh_q, rx_in});
         end
         assign rx_s = sh_q[RX_SYNC_STAGES-1];
      end
   endgenerate

   bs_quantum_gen #(.DIV_W(DIV_W)) u_qgen (
      .clk(clk), .rst_n(rst_n), .div(cfg_div), .q_en(tq_en)
   );

   bs_phase_ctrl #(.QW(QW), .JW(JW)) u_phase (
      .clk(clk), .rst_n(rst_n), .q_en(tq_en), .rx_s(rx_s),
      .hsync_ok(hsync_ok), .tx_dom(~tx_out),
      .cfg_nq(cfg_nq), .cfg_sp(cfg_sp), .cfg_sjw(cfg_sjw),
      .smp_stb(smp_stb), .smp_bit(smp_bit), .bnd_stb(bnd_stb),
      .bnd_evt(bnd_evt), .sync_hit(sync_hit), .cnt_o(q_cnt)
   );

   bs_tx_hold u_tx (
      .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_bit(tx_bit),
      .bnd_evt(bnd_evt), .tx_out(tx_out)
   );
endmodule

// File: rtl/can_bit_sync_chk.sv
module can_bit_sync_chk #(
   parameter int QW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tq_en,
   input logic          smp_stb,
   input logic          smp_bit,
   input logic          bnd_stb,
   input logic          tx_out,
   input logic          rx_s,
   input logic          sync_hit,
   input logic [QW-1:0] cfg_nq,
   input logic [QW-1:0] q_cnt
);
   // R1: strobes only follow a quantum tick
   p_stb_on_quantum_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb || bnd_stb) |-> $past(tq_en));

   // R2: counter stays inside the configured bit length
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt < cfg_nq);

   // R10: sampled value is the line level of the reported quantum
   p_smp_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |-> (smp_bit == $past(rx_s)));

   // R9: transmit level moves only on a boundary
   p_tx_at_bnd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_out) |-> bnd_stb);

   // R8: no synchronization while sending dominant
   p_no_sync_dom_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hit |-> tx_out);
endmodule

bind can_bit_sync can_bit_sync_chk #(.QW(QW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .smp_stb(smp_stb),
   .smp_bit(smp_bit), .bnd_stb(bnd_stb), .tx_out(tx_out), .rx_s(rx_s),
   .sync_hit(sync_hit), .cfg_nq(cfg_nq), .q_cnt(q_cnt)
);

// File: tb/sim_can_bit_sync.sv
module sim_can_bit_sync;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cfg_div = '0;
   logic [4:0] cfg_nq = 5'd8, cfg_sp = 5'd6;
   logic [2:0] cfg_sjw = 3'd2;
   logic       rx_in = 1'b1, hsync_ok = 1'b0, tx_req = 1'b0, tx_bit = 1'b1;
   logic       tq_en, smp_stb, smp_bit, bnd_stb, tx_out;
   int         cyc = 0;
   int         n_chk = 0, n_bad = 0;

   can_bit_sync u0 (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_nq(cfg_nq),
      .cfg_sp(cfg_sp), .cfg_sjw(cfg_sjw), .rx_in(rx_in), .hsync_ok(hsync_ok),
      .tx_req(tx_req), .tx_bit(tx_bit), .tq_en(tq_en), .smp_stb(smp_stb),
      .smp_bit(smp_bit), .bnd_stb(bnd_stb), .tx_out(tx_out)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic go_to(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic drive_at(input int t, input logic v);
      go_to(t - 1);
      rx_in = v;
   endtask

   task automatic wait_bnd(output int t);
      int g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (!bnd_stb && g < 400);
      if (!bnd_stb) chk("R2 boundary strobe missing", 0, 1);
      t = cyc;
   endtask

   task automatic do_reset(input int n, input int sp, input int sjw, input int dv);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_nq = 5'(n); cfg_sp = 5'(sp); cfg_sjw = 3'(sjw); cfg_div = 8'(dv);
      rx_in = 1'b1; hsync_ok = 1'b0; tx_req = 1'b0; tx_bit = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic void expect_sync(input int n, input int sp, input int sjw,
                                       input int j, input bit hard,
                                       output int cn, output bit imm,
                                       output string tag);
      int nc, e, mag, adv;
      nc = j % n;
      if (hard) begin
         cn = 1; imm = 1'b1; tag = "R3 hard sync";
      end else if (nc >= 1 && nc < sp) begin
         e = nc - 1;
         cn = nc - ((e < sjw) ? e : sjw); imm = 1'b0; tag = "R4 late edge";
      end else begin
         mag = (nc == 0) ? 1 : n + 1 - nc;
         tag = "R5 early edge";
         if (mag <= sjw) begin
            cn = 1; imm = 1'b1;
         end else begin
            adv = nc + sjw;
            cn = (adv == n) ? 0 : adv;
            imm = (adv == n);
         end
      end
   endfunction

   task automatic run_case(input int n, input int sp, input int sjw,
                           input int j, input bit hard);
      int t, t2, e_cyc, cn;
      bit imm;
      string tag;
      expect_sync(n, sp, sjw, j, hard, cn, imm, tag);
      wait_bnd(t);
      hsync_ok = hard;
      drive_at(t + j, 1'b0);
      drive_at(t + j + 1, 1'b1);
      hsync_ok = 1'b0;
      e_cyc = cyc;
      chk($sformatf("%s boundary on edge n=%0d sp=%0d sjw=%0d j=%0d", tag, n, sp, sjw, j),
          int'(bnd_stb), int'(imm));
      wait_bnd(t2);
      chk($sformatf("%s next boundary n=%0d sp=%0d sjw=%0d j=%0d", tag, n, sp, sjw, j),
          t2 - e_cyc, (cn == 0) ? n : n - cn);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int t0, t1, t2, cnt;
      int pairs_n[6] = '{8, 8, 8, 13, 25, 25};
      int pairs_s[6] = '{2, 6, 7, 7, 2, 20};

      // reset state
      repeat (2) @(negedge clk);
      chk("R9 tx_out recessive in reset", int'(tx_out), 1);
      chk("R2 boundary strobe idle in reset", int'(bnd_stb), 0);
      chk("R2 sample strobe idle in reset", int'(smp_stb), 0);

      // R1: prescaler, four clocks per quantum
      do_reset(8, 6, 2, 3);
      cnt = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (tq_en) cnt++;
      end
      chk("R1 quantum enables in 40 clocks", cnt, 10);
      wait_bnd(t0);
      wait_bnd(t1);
      chk("R1 boundary spacing in clocks", t1 - t0, 32);

      // R2 and R10: free-running timing for every bit length
      for (int n = 8; n <= 25; n++) begin
         for (int k = 0; k < 2; k++) begin
            int sp = (k == 0) ? 2 : n - 1;
            do_reset(n, sp, 1, 0);
            wait_bnd(t0);
            go_to(t0 + sp - 1);
            chk($sformatf("R2 no sample before position n=%0d sp=%0d", n, sp), int'(smp_stb), 0);
            @(negedge clk);
            chk($sformatf("R2 sample at position n=%0d sp=%0d", n, sp), int'(smp_stb), 1);
            chk($sformatf("R10 recessive sample n=%0d", n), int'(smp_bit), 1);
            wait_bnd(t1);
            chk($sformatf("R2 bit length n=%0d sp=%0d", n, sp), t1 - t0, n);
         end
      end

      // R3, R4, R5: edge sweep
      for (int p = 0; p < 6; p++) begin
         for (int sjw = 1; sjw <= 4; sjw++) begin
            do_reset(pairs_n[p], pairs_s[p], sjw, 0);
            for (int j = 1; j <= pairs_n[p]; j++)
               run_case(pairs_n[p], pairs_s[p], sjw, j, 1'b0);
            if (sjw == 2)
               for (int j = 1; j <= pairs_n[p]; j++)
                  run_case(pairs_n[p], pairs_s[p], sjw, j, 1'b1);
         end
      end

      // R6 and R10: rising edge leaves timing alone, samples follow the line
      do_reset(8, 6, 2, 0);
      wait_bnd(t0);
      drive_at(t0 + 1, 1'b0);
      go_to(t0 + 6);
      chk("R10 dominant sample", int'(smp_bit), 0);
      wait_bnd(t1);
      chk("R6 nominal edge keeps bit length", t1 - t0, 8);
      drive_at(t1 + 4, 1'b1);
      go_to(t1 + 6);
      chk("R10 recessive sample after rise", int'(smp_bit), 1);
      wait_bnd(t2);
      chk("R6 rising edge ignored", t2 - t1, 8);

      // R7: inhibit holds until a recessive sample
      do_reset(8, 6, 2, 0);
      wait_bnd(t0);
      drive_at(t0 + 1, 1'b0);
      drive_at(t0 + 7, 1'b1);
      wait_bnd(t1);
      chk("R7 dominant sample keeps inhibit", t1 - t0, 8);
      drive_at(t1 + 3, 1'b0);
      drive_at(t1 + 4, 1'b1);
      wait_bnd(t2);
      chk("R7 edge ignored while inhibited", t2 - t1, 8);
      drive_at(t2 + 3, 1'b0);
      drive_at(t2 + 4, 1'b1);
      t0 = cyc;
      wait_bnd(t1);
      chk("R7 edge used after recessive sample", t1 - t0, 7);

      // R8 and R9: transmit hold and dominant-send blocking
      do_reset(8, 6, 2, 0);
      wait_bnd(t0);
      go_to(t0 + 6);
      tx_req = 1'b1; tx_bit = 1'b0;
      @(negedge clk);
      tx_req = 1'b0; tx_bit = 1'b1;
      chk("R9 bit held before boundary", int'(tx_out), 1);
      wait_bnd(t1);
      chk("R9 boundary delivery", t1 - t0, 8);
      chk("R9 bit driven at boundary", int'(tx_out), 0);
      drive_at(t1 + 3, 1'b0);
      drive_at(t1 + 4, 1'b1);
      wait_bnd(t2);
      chk("R8 edge ignored while sending dominant", t2 - t1, 8);
      chk("R9 recessive with nothing stored", int'(tx_out), 1);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule